// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It reads up to four levels of 8-byte translation entries from memory, one level at a time. Each request carries the virtual address, a root register value that locates the top-level table, and the kind of access: read or write, instruction fetch or data, and user or supervisor. The walker uses a plain request/response memory port and never has more than one read outstanding.

An address whose upper bits are not a sign extension of bit 47 is turned away before any memory access. A walk stops at the first missing entry. It also stops early when an entry at level 2 or level 3 marks a large page, which gives a 2 MB or 1 GB page. The access rights found along the path are merged, and the result is checked against the access type once the leaf entry is reached.

Each request ends with a single-cycle completion pulse. The pulse carries the physical address, a page size code, a fault code and the level at which the walk ended.

Top module: `page_walker`

## Requirements
- R1: A request whose address bits 63:48 are not all equal to bit 47 completes with fault code 1 (non-canonical) and level 0. It issues no memory read.
- R2: Reads go to levels 4, 3, 2 and 1 in that order. The index for each level comes from address bits 47:39, 38:30, 29:21 and 20:12. The entry address is the table base plus the index times 8. The first table base is root bits 51:12 with the low 12 bits cleared. Each later base is bits 51:12 of the previous entry, so entry bits 63:52 and 11:0 are ignored.
- R3: Only one memory read is outstanding at a time. A read request holds its address until it is accepted. The next read request follows the response to the previous one.
- R4: An entry with bit 0 (present) clear ends the walk with fault code 2 (not present), and the reported level is the level of that entry.
- R5: A walk that reaches level 1 reports size code 0 (4 kB). Its address is bits 51:12 of the level-1 entry joined with virtual address bits 11:0.
- R6: A present level-2 entry with bit 7 (page size) set ends the walk with size code 1 (2 MB). Its address is entry bits 51:21 joined with virtual address bits 20:0.
- R7: A present level-3 entry with bit 7 set ends the walk with size code 2 (1 GB). Its address is entry bits 51:30 joined with virtual address bits 29:0.
- R8: Bit 7 of a level-4 entry has no effect, and the walk continues to level 3.
- R9: Bit 1 marks a writable entry, bit 2 a user entry and bit 63 a no-execute entry. A user access needs bit 2 at every level visited. A write needs bit 1 at every level. A fetch fails if bit 63 is set at any level. A failed check gives fault code 3 (protection) at the leaf level. A clean walk reports fault code 0 and the leaf level.
- R10: The request is taken only while req_ready is high. From the cycle after acceptance through the completion cycle, busy is high and req_ready is low. done is high for exactly one cycle, and the walker is idle again the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 64 | Virtual address to translate |
| req_root | input | 64 | Root register, base of the level-4 table |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access comes from user mode |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 52 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry value |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_pa | output | 52 | Translated physical address |
| done_size | output | 2 | Page size: 0 = 4 kB, 1 = 2 MB, 2 = 1 GB |
| done_fault | output | 2 | 0 none, 1 non-canonical, 2 not present, 3 protection |
| done_level | output | 3 | Level where the walk ended (0 for non-canonical) |

## Verification
The bench builds tables with junk in the ignored bits of the root, the pointer entries and the large-page entries. A walker that masks the frame wrongly reads from or returns a corrupted address. Addresses that break canonical form in either direction must give a fault with no read at all, so a design that checks only one direction, or checks too late, issues a stray read. Rights are withheld at a level above the leaf, so a design that checks only the leaf entry lets the access through. A level-4 entry with the page-size bit set catches a walker that stops too early. The memory model stalls acceptance and varies response latency, so a walker that issues a second read early or drops its address while stalled produces a miscompare on that clock.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      FLT_NONE     = 2'd0,
      FLT_NONCANON = 2'd1,
      FLT_NOTPRES  = 2'd2,
      FLT_PROT     = 2'd3
   } ptw_fault_e;

   typedef enum logic [1:0] {
      PG_4K   = 2'd0,
      PG_2M   = 2'd1,
      PG_1G   = 2'd2,
      PG_RSVD = 2'd3
   } ptw_size_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_ISSUE = 2'd1,
      S_WAIT  = 2'd2,
      S_DONE  = 2'd3
   } ptw_state_e;

   typedef struct packed {
      logic present;
      logic writable;
      logic user;
      logic big;
      logic noexec;
   } ptw_flags_t;

endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
   import ptw_pkg::*;
#(
   parameter int ENTRY_W  = 64,
   parameter int PA_W     = 52,
   parameter int PG_SHIFT = 12,
   parameter int BIT_P    = 0,
   parameter int BIT_W    = 1,
   parameter int BIT_U    = 2,
   parameter int BIT_PS   = 7,
   parameter int BIT_NX   = 63
) (
   input  logic [ENTRY_W-1:0] entry,
   output ptw_flags_t         flags,
   output logic [PA_W-1:0]    frame,
   output logic [PA_W-1:0]    next_base
);

   localparam logic [PA_W-1:0] FRAME_MASK = {{(PA_W-PG_SHIFT){1'b1}}, {PG_SHIFT{1'b0}}};

   if (BIT_P >= ENTRY_W || BIT_W >= ENTRY_W || BIT_U >= ENTRY_W ||
       BIT_PS >= ENTRY_W || BIT_NX >= ENTRY_W) begin : g_bad_bits
      $error("ptw_entry_decode: flag position outside entry");
   end

   logic unused_entry;
   assign unused_entry = ^entry;

   assign flags.present  = entry[BIT_P];
   assign flags.writable = entry[BIT_W];
   assign flags.user     = entry[BIT_U];
   assign flags.big      = entry[BIT_PS];
   assign flags.noexec   = entry[BIT_NX];

   assign frame     = entry[PA_W-1:0];
   assign next_base = entry[PA_W-1:0] & FRAME_MASK;

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int PA_W     = 52,
   parameter int IDX_W    = 9,
   parameter int PG_SHIFT = 12,
   parameter int LEVELS   = 4,
   parameter int ENTRY_W  = 64,
   localparam int VA_KEEP = PG_SHIFT + IDX_W * LEVELS,
   localparam int LVL_W   = $clog2(LEVELS + 1)
) (
   input  logic [VA_KEEP-1:0] va,
   input  logic [PA_W-1:0]    table_base,
   input  logic [LVL_W-1:0]   level,
   input  logic [PA_W-1:0]    leaf_frame,
   output logic [PA_W-1:0]    entry_addr,
   output logic [PA_W-1:0]    leaf_pa
);

   localparam int ENTRY_SHIFT = $clog2(ENTRY_W / 8);

   if (VA_KEEP > PA_W) begin : g_bad_va
      $error("ptw_addr_gen: index field wider than physical address");
   end

   logic [IDX_W-1:0] idx_arr  [1:LEVELS];
   logic [PA_W-1:0]  mask_arr [1:LEVELS];

   for (genvar g = 1; g <= LEVELS; g++) begin : g_lvl
      localparam int SH = PG_SHIFT + IDX_W * (g - 1);
      assign idx_arr[g]  = va[SH +: IDX_W];
      assign mask_arr[g] = {{(PA_W-SH){1'b0}}, {SH{1'b1}}};
   end

   logic [IDX_W-1:0] idx_sel;
   logic [PA_W-1:0]  mask_sel;

   always_comb begin
      idx_sel  = '0;
      mask_sel = '0;
      for (int i = 1; i <= LEVELS; i++) begin
         if (level == LVL_W'(i)) begin
            idx_sel  = idx_arr[i];
            mask_sel = mask_arr[i];
         end
      end
   end

   assign entry_addr = table_base + (PA_W'(idx_sel) << ENTRY_SHIFT);
   assign leaf_pa    = (leaf_frame & ~mask_sel) | (PA_W'(va) & mask_sel);

endmodule

// File: rtl/ptw_rights.sv
module ptw_rights (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic load,
   input  logic ent_user,
   input  logic ent_write,
   input  logic ent_nx,
   input  logic acc_user,
   input  logic acc_write,
   input  logic acc_exec,
   output logic prot_fault
);

   logic sum_u, sum_w, sum_nx;
   logic all_u, all_w, any_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_u  <= 1'b1;
         sum_w  <= 1'b1;
         sum_nx <= 1'b0;
      end else if (clear) begin
         sum_u  <= 1'b1;
         sum_w  <= 1'b1;
         sum_nx <= 1'b0;
      end else if (load) begin
         sum_u  <= sum_u & ent_user;
         sum_w  <= sum_w & ent_write;
         sum_nx <= sum_nx | ent_nx;
      end
   end

   assign all_u  = sum_u & ent_user;
   assign all_w  = sum_w & ent_write;
   assign any_nx = sum_nx | ent_nx;

   assign prot_fault = (acc_user & ~all_u) | (acc_write & ~all_w) | (acc_exec & any_nx);

   AST_NX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_nx && !clear) |=> sum_nx); // R9
   AST_USER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!sum_u && !clear) |=> !sum_u); // R9
   AST_WRITE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!sum_w && !clear) |=> !sum_w); // R9

endmodule

// File: rtl/page_walker.sv
module page_walker
   import ptw_pkg::*;
#(
   parameter int VA_W         = 64,
   parameter int PA_W         = 52,
   parameter int ENTRY_W      = 64,
   parameter int IDX_W        = 9,
   parameter int PG_SHIFT     = 12,
   parameter int LEVELS       = 4,
   parameter int LEAF_MAX_LVL = 3,
   parameter int BIT_P        = 0,
   parameter int BIT_W        = 1,
   parameter int BIT_U        = 2,
   parameter int BIT_PS       = 7,
   parameter int BIT_NX       = 63,
   localparam int LVL_W       = $clog2(LEVELS + 1),
   localparam int VA_KEEP     = PG_SHIFT + IDX_W * LEVELS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_va,
   input  logic [ENTRY_W-1:0] req_root,
   input  logic               req_write,
   input  logic               req_exec,
   input  logic               req_user,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [PA_W-1:0]    mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [ENTRY_W-1:0] mem_rsp_data,
   output logic               busy,
   output logic               done,
   output logic [PA_W-1:0]    done_pa,
   output logic [1:0]         done_size,
   output logic [1:0]         done_fault,
   output logic [LVL_W-1:0]   done_level
);

   localparam int CANON_MSB = VA_KEEP - 1;
   localparam int ENTRY_SHIFT = $clog2(ENTRY_W / 8);
   localparam logic [PA_W-1:0] FRAME_MASK = {{(PA_W-PG_SHIFT){1'b1}}, {PG_SHIFT{1'b0}}};

   if (CANON_MSB >= VA_W) begin : g_bad_canon
      $error("page_walker: index fields exceed virtual address width");
   end
   if (PA_W > ENTRY_W || PA_W <= PG_SHIFT) begin : g_bad_pa
      $error("page_walker: physical width inconsistent with entry width");
   end
   if ((ENTRY_W % 8) != 0 || (1 << ENTRY_SHIFT) * 8 != ENTRY_W) begin : g_bad_entry
      $error("page_walker: entry width must be a power-of-two byte count");
   end
   if (LEAF_MAX_LVL >= LEVELS || LEAF_MAX_LVL < 1) begin : g_bad_leaf
      $error("page_walker: large-page level range invalid");
   end

   ptw_state_e         state;
   logic [VA_KEEP-1:0] va_q;
   logic [PA_W-1:0]    base_q;
   logic [LVL_W-1:0]   level_q;
   logic               wr_q, ex_q, us_q;
   logic [PA_W-1:0]    pa_q;
   ptw_size_e          size_q;
   ptw_fault_e         fault_q;
   logic [LVL_W-1:0]   end_lvl_q;
   logic               rd_issued;

   logic unused_inputs;
   assign unused_inputs = ^{req_root, req_va};

   logic canon;
   assign canon = (&req_va[VA_W-1:CANON_MSB]) | ~(|req_va[VA_W-1:CANON_MSB]);

   logic accept;
   assign accept = (state == S_IDLE) && req_valid;

   ptw_flags_t      ent_f;
   logic [PA_W-1:0] ent_frame, ent_next;

   ptw_entry_decode #(
      .ENTRY_W(ENTRY_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT),
      .BIT_P(BIT_P), .BIT_W(BIT_W), .BIT_U(BIT_U), .BIT_PS(BIT_PS), .BIT_NX(BIT_NX)
   ) u_dec (
      .entry    (mem_rsp_data),
      .flags    (ent_f),
      .frame    (ent_frame),
      .next_base(ent_next)
   );

   logic [PA_W-1:0] entry_addr, leaf_pa;

   ptw_addr_gen #(
      .PA_W(PA_W), .IDX_W(IDX_W), .PG_SHIFT(PG_SHIFT), .LEVELS(LEVELS), .ENTRY_W(ENTRY_W)
   ) u_addr (
      .va        (va_q),
      .table_base(base_q),
      .level     (level_q),
      .leaf_frame(ent_frame),
      .entry_addr(entry_addr),
      .leaf_pa   (leaf_pa)
   );

   logic rsp_take;
   assign rsp_take = (state == S_WAIT) && mem_rsp_valid;

   logic prot_fault;

   ptw_rights u_rights (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .load      (rsp_take && ent_f.present),
      .ent_user  (ent_f.user),
      .ent_write (ent_f.writable),
      .ent_nx    (ent_f.noexec),
      .acc_user  (us_q),
      .acc_write (wr_q),
      .acc_exec  (ex_q),
      .prot_fault(prot_fault)
   );

   logic big_ok;
   if (LEAF_MAX_LVL >= 2) begin : g_big
      assign big_ok = (level_q >= LVL_W'(2)) && (level_q <= LVL_W'(LEAF_MAX_LVL));
   end else begin : g_no_big
      assign big_ok = 1'b0;
   end

   logic is_leaf;
   assign is_leaf = (level_q == LVL_W'(1)) || (ent_f.big && big_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         va_q      <= '0;
         base_q    <= '0;
         level_q   <= '0;
         wr_q      <= 1'b0;
         ex_q      <= 1'b0;
         us_q      <= 1'b0;
         pa_q      <= '0;
         size_q    <= PG_4K;
         fault_q   <= FLT_NONE;
         end_lvl_q <= '0;
         rd_issued <= 1'b0;
      end else begin
         case (state)
            S_IDLE: begin
               if (req_valid) begin
                  va_q      <= req_va[VA_KEEP-1:0];
                  base_q    <= req_root[PA_W-1:0] & FRAME_MASK;
                  level_q   <= LVL_W'(LEVELS);
                  wr_q      <= req_write;
                  ex_q      <= req_exec;
                  us_q      <= req_user;
                  rd_issued <= 1'b0;
                  if (canon) begin
                     state <= S_ISSUE;
                  end else begin
                     fault_q   <= FLT_NONCANON;
                     end_lvl_q <= '0;
                     pa_q      <= '0;
                     size_q    <= PG_4K;
                     state     <= S_DONE;
                  end
               end
            end
            S_ISSUE: begin
               if (mem_req_ready) begin
                  rd_issued <= 1'b1;
                  state     <= S_WAIT;
               end
            end
            S_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!ent_f.present) begin
                     fault_q   <= FLT_NOTPRES;
                     end_lvl_q <= level_q;
                     pa_q      <= '0;
                     size_q    <= PG_4K;
                     state     <= S_DONE;
                  end else if (is_leaf) begin
                     fault_q   <= prot_fault ? FLT_PROT : FLT_NONE;
                     end_lvl_q <= level_q;
                     pa_q      <= leaf_pa;
                     size_q    <= ptw_size_e'(2'(level_q - LVL_W'(1)));
                     state     <= S_DONE;
                  end else begin
                     base_q  <= ent_next;
                     level_q <= level_q - LVL_W'(1);
                     state   <= S_ISSUE;
                  end
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == S_IDLE);
   assign busy          = (state != S_IDLE);
   assign done          = (state == S_DONE);
   assign mem_req_valid = (state == S_ISSUE);
   assign mem_req_addr  = entry_addr;
   assign done_pa       = pa_q;
   assign done_size     = size_q;
   assign done_fault    = fault_q;
   assign done_level    = end_lvl_q;

   AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R3
   AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R3
   AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[ENTRY_SHIFT-1:0] == '0)); // R2
   AST_NONCANON_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault == FLT_NONCANON) |-> !rd_issued); // R1
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready)); // R10
   AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault == FLT_NONE) |-> (done_pa[PG_SHIFT-1:0] == va_q[PG_SHIFT-1:0])); // R5
   AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault != FLT_NONCANON) |->
         (done_level >= LVL_W'(1) && done_level <= LVL_W'(LEVELS))); // R4

endmodule

// File: tb/page_walker_bench.sv
`timescale 1ns/1ps
module page_walker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_va = '0;
   logic [63:0] req_root = '0;
   logic        req_write = 1'b0, req_exec = 1'b0, req_user = 1'b0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [51:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        busy, done;
   logic [51:0] done_pa;
   logic [1:0]  done_size, done_fault;
   logic [2:0]  done_level;

   always #2 clk = ~clk;

   page_walker u_page_walker (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_root(req_root),
      .req_write(req_write), .req_exec(req_exec), .req_user(req_user),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .busy(busy), .done(done), .done_pa(done_pa), .done_size(done_size),
      .done_fault(done_fault), .done_level(done_level)
   );

   int nvec = 0;
   int nbad = 0;
   logic [63:0] pmem [logic [51:0]];
   logic [51:0] exp_q [$];
   int          rd_count = 0;
   int          cyc = 0;
   bit          finished = 0;

   localparam logic [51:0] M4K = 52'hF_FFFF_FFFF_F000;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] ent(input logic [63:0] frame, input bit w, input bit u,
                                       input bit ps, input bit nx);
      logic [63:0] e;
      e = frame;
      e[0] = 1'b1; e[1] = w; e[2] = u; e[7] = ps; e[63] = nx;
      return e;
   endfunction

   function automatic logic [63:0] mkva(input int i4, input int i3, input int i2,
                                        input int i1, input int off);
      logic [63:0] v;
      v = (64'(i4) << 39) | (64'(i3) << 30) | (64'(i2) << 21) | (64'(i1) << 12) | 64'(off);
      if (v[47]) v[63:48] = '1;
      return v;
   endfunction

   task automatic put(input logic [51:0] tbl, input int idx, input logic [63:0] e);
      pmem[tbl + 52'(idx * 8)] = e;
   endtask

   // behavioural reference walk
   task automatic walk_ref(input logic [63:0] va, input logic [63:0] root,
                           input bit w, input bit x, input bit u,
                           output logic [51:0] pa, output int sz, output int flt, output int lvl);
      logic [51:0] base, a, msk;
      logic [63:0] e;
      bit ua, wa, nxa;
      exp_q.delete();
      pa = '0; sz = 0;
      if (va[63:47] != '0 && va[63:47] != '1) begin
         flt = 1; lvl = 0;
         return;
      end
      base = root[51:0] & M4K;
      ua = 1; wa = 1; nxa = 0;
      for (int l = 4; l >= 1; l--) begin
         int idx;
         idx = int'((va >> (12 + 9 * (l - 1))) & 64'd511);
         a = base + 52'(idx * 8);
         exp_q.push_back(a);
         e = pmem.exists(a) ? pmem[a] : 64'd0;
         if (!e[0]) begin
            flt = 2; lvl = l;
            return;
         end
         ua &= e[2]; wa &= e[1]; nxa |= e[63];
         if (l == 1 || ((l == 2 || l == 3) && e[7])) begin
            msk = (52'd1 << (12 + 9 * (l - 1))) - 52'd1;
            pa  = (e[51:0] & ~msk) | (va[51:0] & msk);
            sz  = l - 1;
            lvl = l;
            flt = ((u && !ua) || (w && !wa) || (x && nxa)) ? 3 : 0;
            return;
         end
         base = e[51:0] & M4K;
      end
   endtask

   // memory responder: stalls acceptance, varies latency, checks reads on every clock
   initial begin : responder
      bit          outst;
      int          cnt;
      logic [51:0] ra;
      outst = 0; cnt = 0; ra = '0;
      forever begin
         @(negedge clk);
         cyc++;
         mem_rsp_valid = 1'b0;
         if (outst) begin
            chk(!mem_req_valid, "R3", "read issued while one outstanding", 64'(mem_req_valid), 0);
            cnt--;
            if (cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = pmem.exists(ra) ? pmem[ra] : 64'd0;
               outst = 0;
            end
         end
         mem_req_ready = ((cyc % 3) != 0);
         if (!outst && mem_req_valid && mem_req_ready) begin
            ra = mem_req_addr;
            rd_count++;
            if (exp_q.size() == 0) begin
               chk(0, "R1", "unexpected memory read", 64'(ra), 0);
            end else begin
               chk(ra == exp_q[0], "R2", "entry address", 64'(ra), 64'(exp_q[0]));
               void'(exp_q.pop_front());
            end
            outst = 1;
            cnt = 1 + (rd_count % 3);
         end
      end
   end

   task automatic run(input logic [63:0] va, input logic [63:0] root,
                      input bit w, input bit x, input bit u, input string tag);
      logic [51:0] epa;
      int esz, eflt, elvl, nexp, t;
      walk_ref(va, root, w, x, u, epa, esz, eflt, elvl);
      nexp = exp_q.size();
      rd_count = 0;
      @(negedge clk);
      chk(req_ready && !busy, "R10", "idle before request", 64'(req_ready), 1);
      req_va = va; req_root = root; req_write = w; req_exec = x; req_user = u;
      req_valid = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0;
      t = 0;
      forever begin
         @(negedge clk);
         chk(busy && !req_ready, "R10", "busy during walk", 64'(busy), 1);
         if (done) break;
         t++;
         if (t > 300) begin
            chk(0, tag, "walk timeout", 0, 1);
            return;
         end
      end
      chk(done_fault == 2'(eflt), tag, "fault code", 64'(done_fault), 64'(eflt));
      chk(done_level == 3'(elvl), tag, "end level", 64'(done_level), 64'(elvl));
      if (eflt == 0) begin
         chk(done_pa == epa, tag, "physical address", 64'(done_pa), 64'(epa));
         chk(done_size == 2'(esz), tag, "page size", 64'(done_size), 64'(esz));
      end
      chk(rd_count == nexp, (eflt == 1) ? "R1" : "R3", "read count", 64'(rd_count), 64'(nexp));
      @(negedge clk);
      chk(!done && !busy && req_ready, "R10", "done single pulse", 64'(done), 0);
   endtask

   initial begin : watchdog
      #800000;
      if (!finished) begin
         nbad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin : main
      logic [63:0] root;
      root = 64'h1000_0000_0000_1018;   // noise above bit 51 and below bit 12
      // user space path
      put(52'h1000, 1, ent(64'h2000, 1, 1, 0, 0));
      put(52'h2000, 2, ent(64'h3000, 1, 1, 0, 0));
      put(52'h3000, 3, ent(64'h0080_0000_0000_4000, 1, 1, 0, 0)); // noise bit 55
      put(52'h4000, 4, ent(64'h1234_5000, 1, 1, 0, 0));
      put(52'h3000, 5, ent(64'h4001_F000, 1, 1, 1, 0));           // 2M, noise 16:12
      put(52'h2000, 6, ent(64'hC234_5000, 1, 1, 1, 0));           // 1G, noise 29:12
      // kernel path, supervisor at level 3
      put(52'h1000, 511, ent(64'h5000, 1, 1, 0, 0));
      put(52'h5000, 511, ent(64'h6000, 1, 0, 0, 0));
      put(52'h6000, 0,   ent(64'h7000, 1, 1, 0, 0));
      put(52'h7000, 0,   ent(64'h9000, 1, 1, 0, 0));
      // read-only at level 2
      put(52'h2000, 12, ent(64'h8000, 1, 1, 0, 0));
      put(52'h8000, 0,  ent(64'hA000, 0, 1, 0, 0));
      put(52'hA000, 0,  ent(64'h55000, 1, 1, 0, 0));
      // no-execute at level 4
      put(52'h1000, 20, ent(64'hB000, 1, 1, 0, 1));
      put(52'hB000, 0,  ent(64'h4000_0000, 1, 1, 1, 0));
      // page-size bit at level 4 must be ignored
      put(52'h1000, 30, ent(64'hC000, 1, 1, 1, 0));
      put(52'hC000, 1,  ent(64'hD000, 1, 1, 0, 0));
      put(52'hD000, 2,  ent(64'hE000, 1, 1, 0, 0));
      put(52'hE000, 3,  ent(64'h7777_7000, 1, 1, 0, 0));

      repeat (3) @(negedge clk);
      chk(!busy && !done && !mem_req_valid && req_ready, "R10", "reset state",
          {busy, done, mem_req_valid, req_ready}, 64'h1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run(mkva(1, 2, 3, 4, 12'hABC), root, 0, 0, 1, "R5");
      run(mkva(1, 2, 3, 4, 12'h008), root, 1, 1, 0, "R5");
      run(mkva(1, 2, 5, 300, 12'h123), root, 0, 0, 1, "R6");
      run(mkva(1, 6, 99, 7, 12'hFFF), root, 1, 0, 1, "R7");
      run(mkva(7, 0, 0, 0, 0), root, 0, 0, 0, "R4");
      run(mkva(1, 8, 0, 0, 0), root, 0, 0, 0, "R4");
      run(mkva(1, 2, 9, 0, 0), root, 0, 0, 0, "R4");
      run(mkva(1, 2, 3, 10, 0), root, 0, 0, 0, "R4");
      run(64'h0001_0000_0000_1000, root, 0, 0, 0, "R1");
      run(64'h0000_8000_0000_1000, root, 0, 0, 0, "R1");
      run(64'h7FFF_FFFF_FFFF_F000, root, 0, 0, 0, "R1");
      run(mkva(511, 511, 0, 0, 12'h010), root, 0, 0, 0, "R9");
      run(mkva(511, 511, 0, 0, 12'h010), root, 0, 0, 1, "R9");
      run(mkva(1, 12, 0, 0, 12'h044), root, 0, 0, 1, "R9");
      run(mkva(1, 12, 0, 0, 12'h044), root, 1, 0, 1, "R9");
      run(mkva(20, 0, 5, 5, 12'h100), root, 0, 0, 1, "R9");
      run(mkva(20, 0, 5, 5, 12'h100), root, 0, 1, 1, "R9");
      run(mkva(30, 1, 2, 3, 12'h5A5), root, 0, 0, 1, "R8");
      run(mkva(1, 2, 3, 4, 12'h777), 64'h1000, 0, 1, 0, "R2");

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule